// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a logical address into a physical address. A logical address is a segment number paired with an offset inside that segment. A small on-chip table holds one entry per segment. Each entry stores a physical base, a segment length (the limit), a valid flag and three permission flags for read, write and execute. Software fills the entries one at a time through a write port. A separate write port sets a table-length register. Segment numbers at or above that length are treated as illegal.

Each lookup carries a segment number, an offset and an access kind, and it is accepted with a valid/ready handshake. One cycle later the unit returns either the physical address, which is the base plus the offset, or a two-bit fault code. The fault code says whether the segment was bad, the offset broke the limit, or the access kind was not permitted. When more than one fault applies, a fixed priority chooses which code is reported.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every table entry is invalid and the table length is 0, so any lookup returns fault code 01. `rspValid` is 0 while reset is held.
- R2: `reqReady` is held high once reset is released. An accepted request (`reqValid` and `reqReady` both high) produces `rspValid` high on exactly the next cycle. `rspValid` is never high at any other time.
- R3: A lookup with no fault returns fault code 00, and `rspAddr` equals the entry base plus the offset, modulo 2^PA_W.
- R4: A segment number greater than or equal to the table length gives fault code 01.
- R5: A segment whose entry valid flag is 0 gives fault code 01.
- R6: An offset greater than or equal to the entry limit gives fault code 10. An offset exactly equal to the limit therefore faults.
- R7: The access kind encoding is 00 read, 01 write, 10 execute, 11 reserved. The permission field has bit 0 for read, bit 1 for write and bit 2 for execute. An access whose bit is clear gives fault code 11, and the reserved kind always gives fault code 11.
- R8: When several faults apply, code 01 wins over code 10, and code 10 wins over code 11.
- R9: A write to the table or to the length register takes effect on the next cycle. A lookup in the same cycle as the write sees the old contents.
- R10: A faulted response returns `rspAddr` equal to 0.
- R11: Load the table {0: base 219, limit 600; 1: base 2300, limit 14; 2: base 90, limit 100; 3: base 1327, limit 580; 4: base 1952, limit 96}, with length 5 and all permissions granted. Then (1,100) gives fault 10, (2,0) gives address 90, and (3,580) gives fault 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWe | input | 1 | Table entry write strobe |
| tblIdx | input | SEG_W | Entry index to write |
| tblBase | input | PA_W | Physical base of the segment |
| tblLimit | input | OFF_W+1 | Segment length |
| tblValid | input | 1 | Entry valid flag |
| tblPerm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| lenWe | input | 1 | Table-length write strobe |
| lenData | input | SEG_W+1 | New table length |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Unit can accept a lookup |
| reqSeg | input | SEG_W | Segment number |
| reqOff | input | OFF_W | Offset within the segment |
| reqAcc | input | 2 | Access kind |
| rspValid | output | 1 | Response valid |
| rspAddr | output | PA_W | Physical address, 0 on fault |
| rspFault | output | 2 | 00 ok, 01 bad segment, 10 limit, 11 permission |

## Verification
The hardest cases to reach are the ones where several faults apply at once, because priority only shows when more than one check fails. The other hard case is a table write racing a lookup of the same entry. The bench programs every entry with a computed limit and permission pattern, and it sets the length below the table size. It then sweeps every segment against offsets at the limit minus one, at the limit and above it, under all four access kinds. In a separate step, the bench drives a table write and a lookup of the same segment on the same clock edge.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_SEG   = 2'b01,
    FLT_LIMIT = 2'b10,
    FLT_PERM  = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic capture;
    logic tblLoad;
    logic lenLoad;
  } ctrlStrobes_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         tblWe,
  input  logic         lenWe,
  output logic         reqReady,
  output logic         rspValid,
  output ctrlStrobes_t strobes
);

  logic readyQ;
  logic rspValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      rspValidQ <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      rspValidQ <= reqValid && readyQ;
    end
  end

  always_comb begin
    strobes.capture = reqValid && readyQ;
    strobes.tblLoad = tblWe;
    strobes.lenLoad = lenWe;
  end

  assign reqReady = readyQ;
  assign rspValid = rspValidQ;

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [SEG_W-1:0]   tblIdx,
  input  logic [PA_W-1:0]    tblBase,
  input  logic [OFF_W:0]     tblLimit,
  input  logic               tblValid,
  input  logic [2:0]         tblPerm,
  input  logic [SEG_W:0]     lenData,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [1:0]         reqAcc,
  output logic [PA_W-1:0]    rspAddr,
  output logic [1:0]         rspFault
);

  localparam int NUM_SEG = 1 << SEG_W;
  localparam int LIM_W   = OFF_W + 1;

  logic [PA_W-1:0]  baseAll  [NUM_SEG];
  logic [LIM_W-1:0] limitAll [NUM_SEG];
  logic [NUM_SEG-1:0] validAll;
  logic [2:0]       permAll  [NUM_SEG];
  logic [SEG_W:0]   lenQ;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gEntry
    logic [PA_W-1:0]  baseQ;
    logic [LIM_W-1:0] limitQ;
    logic             validQ;
    logic [2:0]       permQ;
    wire hit = strobes.tblLoad && (tblIdx == SEG_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
      end else if (hit) begin
        validQ <= tblValid;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        baseQ  <= tblBase;
        limitQ <= tblLimit;
        permQ  <= tblPerm;
      end
    end

    assign baseAll[g]  = baseQ;
    assign limitAll[g] = limitQ;
    assign validAll[g] = validQ;
    assign permAll[g]  = permQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lenQ <= '0;
    else if (strobes.lenLoad) lenQ <= lenData;
  end

  logic             segBad, limBad, permBad;
  logic [2:0]       selPerm;
  logic [LIM_W-1:0] selLimit;
  fault_e           faultNext;
  logic [PA_W-1:0]  addrNext;

  always_comb begin
    selPerm  = permAll[reqSeg];
    selLimit = limitAll[reqSeg];
    segBad   = ({1'b0, reqSeg} >= lenQ) || !validAll[reqSeg];
    limBad   = {1'b0, reqOff} >= selLimit;
    unique case (acc_e'(reqAcc))
      ACC_READ:  permBad = !selPerm[0];
      ACC_WRITE: permBad = !selPerm[1];
      ACC_EXEC:  permBad = !selPerm[2];
      default:   permBad = 1'b1;
    endcase
    if (segBad)       faultNext = FLT_SEG;
    else if (limBad)  faultNext = FLT_LIMIT;
    else if (permBad) faultNext = FLT_PERM;
    else              faultNext = FLT_NONE;
    addrNext = (faultNext == FLT_NONE) ?
               baseAll[reqSeg] + PA_W'(reqOff) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspAddr  <= '0;
      rspFault <= FLT_NONE;
    end else if (strobes.capture) begin
      rspAddr  <= addrNext;
      rspFault <= faultNext;
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tblWe,
  input  logic [SEG_W-1:0] tblIdx,
  input  logic [PA_W-1:0]  tblBase,
  input  logic [OFF_W:0]   tblLimit,
  input  logic             tblValid,
  input  logic [2:0]       tblPerm,
  input  logic             lenWe,
  input  logic [SEG_W:0]   lenData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOff,
  input  logic [1:0]       reqAcc,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspAddr,
  output logic [1:0]       rspFault
);

  ctrlStrobes_t strobes;

  seg_xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tblWe(tblWe),
    .lenWe(lenWe), .reqReady(reqReady), .rspValid(rspValid),
    .strobes(strobes)
  );

  seg_xlate_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tblIdx(tblIdx),
    .tblBase(tblBase), .tblLimit(tblLimit), .tblValid(tblValid),
    .tblPerm(tblPerm), .lenData(lenData), .reqSeg(reqSeg),
    .reqOff(reqOff), .reqAcc(reqAcc), .rspAddr(rspAddr),
    .rspFault(rspFault)
  );

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             lenWe,
  input logic [SEG_W:0]   lenData,
  input logic             reqValid,
  input logic             reqReady,
  input logic [SEG_W-1:0] reqSeg,
  input logic             rspValid,
  input logic [PA_W-1:0]  rspAddr,
  input logic [1:0]       rspFault
);

  logic [SEG_W:0] shadowLen;
  always_ff @(posedge clk) begin
    if (!rstN) shadowLen <= '0;
    else if (lenWe) shadowLen <= lenData;
  end

  wire fire = reqValid && reqReady;

  AST_RSP_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> rspValid);  // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> !rspValid);  // R2
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> reqReady);  // R2
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'b00) |-> rspAddr == '0);  // R10
  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (fire && ({1'b0, reqSeg} >= shadowLen)) |=> rspFault == 2'b01);  // R4

endmodule

bind seg_xlate_unit seg_xlate_checker #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .lenWe(lenWe), .lenData(lenData),
  .reqValid(reqValid), .reqReady(reqReady), .reqSeg(reqSeg),
  .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault)
);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int NSEG  = 1 << SEG_W;

  logic clk = 0, rstN = 0;
  logic tblWe = 0, tblValid = 0, lenWe = 0, reqValid = 0;
  logic [SEG_W-1:0] tblIdx = 0, reqSeg = 0;
  logic [PA_W-1:0] tblBase = 0;
  logic [OFF_W:0] tblLimit = 0;
  logic [2:0] tblPerm = 0;
  logic [SEG_W:0] lenData = 0;
  logic [OFF_W-1:0] reqOff = 0;
  logic [1:0] reqAcc = 0;
  logic reqReady, rspValid;
  logic [PA_W-1:0] rspAddr;
  logic [1:0] rspFault;

  int tests = 0, fails = 0;
  logic [PA_W-1:0] mBase [NSEG];
  logic [OFF_W:0] mLim [NSEG];
  logic mVal [NSEG];
  logic [2:0] mPerm [NSEG];
  int mLen = 0;

  always #4 clk = ~clk;  // 125 MHz

  seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrEntry(int s, int b, int l, logic v, logic [2:0] p);
    @(negedge clk);
    tblWe = 1; tblIdx = SEG_W'(s); tblBase = PA_W'(b);
    tblLimit = (OFF_W+1)'(l); tblValid = v; tblPerm = p;
    @(negedge clk);
    tblWe = 0;
    mBase[s] = PA_W'(b); mLim[s] = (OFF_W+1)'(l); mVal[s] = v; mPerm[s] = p;
  endtask

  task automatic wrLen(int n);
    @(negedge clk);
    lenWe = 1; lenData = (SEG_W+1)'(n);
    @(negedge clk);
    lenWe = 0; mLen = n;
  endtask

  function automatic logic [1:0] expFault(int s, int o, int a);
    logic pok;
    if (s >= mLen || !mVal[s]) return 2'b01;
    if (o >= int'(mLim[s])) return 2'b10;
    pok = (a == 3) ? 1'b0 : mPerm[s][a];
    return pok ? 2'b00 : 2'b11;
  endfunction

  task automatic lookup(int s, int o, int a, string req);
    logic [1:0] ef;
    logic [PA_W-1:0] ea;
    ef = expFault(s, o, a);
    ea = (ef == 2'b00) ? PA_W'(int'(mBase[s]) + o) : '0;
    @(negedge clk);
    reqValid = 1; reqSeg = SEG_W'(s); reqOff = OFF_W'(o); reqAcc = 2'(a);
    @(negedge clk);
    reqValid = 0;
    check({req, " rspValid"}, 32'(rspValid), 1);
    check({req, " fault"}, 32'(rspFault), 32'(ef));
    check({req, " addr"}, 32'(rspAddr), 32'(ea));
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      mVal[i] = 0; mBase[i] = 0; mLim[i] = 0; mPerm[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 rspValid in reset", 32'(rspValid), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check("R2 ready", 32'(reqReady), 1);
    check("R2 idle rspValid", 32'(rspValid), 0);
    for (int s = 0; s < NSEG; s++) lookup(s, 0, 0, "R1 reset lookup");

    // R11 worked example
    wrEntry(0, 219, 600, 1, 3'b111);
    wrEntry(1, 2300, 14, 1, 3'b111);
    wrEntry(2, 90, 100, 1, 3'b111);
    wrEntry(3, 1327, 580, 1, 3'b111);
    wrEntry(4, 1952, 96, 1, 3'b111);
    wrLen(5);
    lookup(1, 100, 0, "R11 (1,100)");
    lookup(2, 0, 0, "R11 (2,0)");
    lookup(3, 580, 0, "R11 (3,580)");

    // R3 R4 R5 R6 R7 R8 R10 sweep
    for (int s = 0; s < NSEG; s++)
      wrEntry(s, 60000 + s * 1111, 3 + s * 500, (s != 2),
              3'(s + 1));
    wrLen(6);
    for (int s = 0; s < NSEG; s++) begin
      int offs [5];
      offs[0] = 0; offs[1] = int'(mLim[s]) - 1; offs[2] = int'(mLim[s]);
      offs[3] = int'(mLim[s]) + 1; offs[4] = 4095;
      for (int k = 0; k < 5; k++)
        for (int a = 0; a < 4; a++)
          lookup(s, offs[k], a, "R3/R4/R5/R6/R7/R8 sweep");
    end
    // offset exactly at limit (R6) with reserved access (R8 priority)
    lookup(1, int'(mLim[1]), 3, "R6 R8 limit over perm");
    lookup(2, 0, 3, "R5 R8 seg over perm");
    lookup(7, 0, 0, "R4 out of range");

    // R9 same-cycle write and lookup
    @(negedge clk);
    tblWe = 1; tblIdx = 3'd2; tblBase = 16'd500; tblLimit = 13'd50;
    tblValid = 1; tblPerm = 3'b001;
    reqValid = 1; reqSeg = 3'd2; reqOff = 12'd10; reqAcc = 2'd0;
    @(negedge clk);
    tblWe = 0; reqValid = 0;
    check("R9 old entry seen", 32'(rspFault), 1);
    mBase[2] = 16'd500; mLim[2] = 13'd50; mVal[2] = 1; mPerm[2] = 3'b001;
    lookup(2, 10, 0, "R9 new entry");
    check("R9 address", 32'(rspAddr), 510);

    @(negedge clk);
    check("R2 no response without request", 32'(rspValid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule